// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a flash device after a program or erase command has been sent to it. A single-cycle `start` pulse hands it a status address. It then reads the device's 8-bit status word through a simple request/acknowledge read port, two reads at a time. While an embedded operation is running, one status bit flips on every read. When that bit holds still across a read pair, the operation is over and the block reports a pass.

While the bit keeps flipping, the block looks at a second status bit that the device raises once its internal time limit has run out. If that bit is clear, the block reads another pair. If it is set, one more pair of reads decides the result. A steady flip bit in that last pair still counts as a pass. A flip bit that is still moving counts as a fail, and the block writes the reset command back to the device so that it returns to array reads.

An optional cap on the number of read pairs turns a device that never settles into a fail. The result comes out as a one-cycle `done` pulse together with `pass` or `fail`, and these two flags hold until the next accepted start.

Top module: `tbp_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `done`, `pass`, `fail`, `rd_req` and `wr_req` are all low.
- R2: Every status read uses the address captured at the accepted start. `rd_req` and `rd_addr` hold steady until the cycle where `rd_ack` is high, and the data is taken in that cycle. Reads and writes never overlap, and a poll step always consists of two reads.
- R3: If bit 6 of the status has the same value in both reads of a pair, the block reports pass. It issues no further reads and no write.
- R4: If bit 6 differs within a pair and bit 5 of the second read is 0, the block reads another pair (unless R9 applies).
- R5: If bit 6 differs and bit 5 of the second read is 1, the block makes exactly two more reads. If bit 6 is equal across those two reads, it reports pass.
- R6: If bit 6 still differs in that confirming pair, the block writes the value F0h once to the captured address and then reports fail. Fail is never reported without this write.
- R7: `done` is high for exactly one cycle per poll, and in that cycle exactly one of `pass` and `fail` is high. The flags hold until the next accepted start, which clears them on the clock edge that accepts it.
- R8: A `start` pulse that arrives while a poll is running has no effect. The status address is not recaptured, the read sequence is unchanged, and only one `done` occurs.
- R9: When `MAX_POLLS` is nonzero, a poll whose pair number `MAX_POLLS` still shows bit 6 differing with bit 5 clear ends in fail, with the reset write of R6. After that it makes no more reads. A value of 0 removes the cap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a poll; accepted only when idle |
| poll_addr | input | AW | Status address, captured at the accepted start |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read acknowledge; `rd_data` is valid in the same cycle |
| rd_data | input | 8 | Status word from the device |
| wr_req | output | 1 | Write request, held until acknowledged |
| wr_addr | output | AW | Write address |
| wr_data | output | 8 | Write data (reset command F0h) |
| wr_ack | input | 1 | Write acknowledge |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation completed; held until the next start |
| fail | output | 1 | Operation failed; held until the next start |

## Verification
The bench builds status streams in which bit 6 flips for a chosen number of reads and bit 5 rises at a chosen read. It predicts the verdict, the number of reads and the number of writes from the rules above, and sets these against the counts seen on the ports. The targeted corners are these:
- A pair that is stable at once. A design that always polls twice would show extra reads.
- A confirming pair that has settled. Reporting fail as soon as bit 5 is seen would give a false fail and a spurious reset write.
- A confirming pair that still flips. Skipping the reset write leaves the device out of array mode.
- A device that never settles under the cap. Mishandling the cap either hangs or stops one pair early or late, which shows as a wrong read count.
- A second `start` in the middle of a run. A design that honours it would restart or move to the new address, which shows as extra reads, address errors or a second `done`.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    localparam logic [7:0]  TBP_RESET_CMD   = 8'hF0;
    localparam int unsigned TBP_TOGGLE_POS  = 6;
    localparam int unsigned TBP_TIMEOUT_POS = 5;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_A,
        ST_RD_B,
        ST_EVAL,
        ST_CF_A,
        ST_CF_B,
        ST_CEVAL,
        ST_RESET_WR
    } tbp_state_e;

    typedef struct packed {
        logic toggled;
        logic expired;
    } tbp_flags_t;

    function automatic logic is_fetch_state(tbp_state_e s);
        return (s == ST_RD_A) || (s == ST_RD_B) || (s == ST_CF_A) || (s == ST_CF_B);
    endfunction

    function automatic logic is_first_of_pair(tbp_state_e s);
        return (s == ST_RD_A) || (s == ST_CF_A);
    endfunction

    function automatic logic is_second_of_pair(tbp_state_e s);
        return (s == ST_RD_B) || (s == ST_CF_B);
    endfunction

endpackage

// File: rtl/tbp_pair_judge.sv
module tbp_pair_judge
    import tbp_pkg::*;
#(
    parameter int unsigned TOG_POS = TBP_TOGGLE_POS,
    parameter int unsigned TMO_POS = TBP_TIMEOUT_POS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_first,
    input  logic       load_second,
    input  logic [7:0] sample,
    output tbp_flags_t flags
);
    localparam logic [7:0] TOG_MASK = 8'(1 << TOG_POS);
    localparam logic [7:0] TMO_MASK = 8'(1 << TMO_POS);

    logic [7:0] first_q;
    logic [7:0] second_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q  <= '0;
            second_q <= '0;
        end else begin
            if (load_first)  first_q  <= sample;
            if (load_second) second_q <= sample;
        end
    end

    // Flip bit compared across the pair; limit bit taken from the later read.
    assign flags.toggled = |((first_q ^ second_q) & TOG_MASK);
    assign flags.expired = |(second_q & TMO_MASK);

endmodule

// File: rtl/tbp_rd_port.sv
module tbp_rd_port #(
    parameter int unsigned AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [AW-1:0] go_addr,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [7:0]    rd_data,
    output logic          got,
    output logic [7:0]    got_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_req   <= 1'b0;
            rd_addr  <= '0;
            got      <= 1'b0;
            got_data <= '0;
        end else begin
            got <= 1'b0;
            if (rd_req) begin
                if (rd_ack) begin
                    rd_req   <= 1'b0;
                    got      <= 1'b1;
                    got_data <= rd_data;
                end
            end else if (go) begin
                rd_req  <= 1'b1;
                rd_addr <= go_addr;
            end
        end
    end

endmodule

// File: rtl/tbp_wr_port.sv
module tbp_wr_port #(
    parameter int unsigned AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [AW-1:0] go_addr,
    input  logic [7:0]    go_data,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    input  logic          wr_ack,
    output logic          sent
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_req  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            sent    <= 1'b0;
        end else begin
            sent <= 1'b0;
            if (wr_req) begin
                if (wr_ack) begin
                    wr_req <= 1'b0;
                    sent   <= 1'b1;
                end
            end else if (go) begin
                wr_req  <= 1'b1;
                wr_addr <= go_addr;
                wr_data <= go_data;
            end
        end
    end

endmodule

// File: rtl/tbp_poll_limit.sv
module tbp_poll_limit #(
    parameter int unsigned MAX_POLLS = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic at_cap
);
    generate
        if (MAX_POLLS == 0) begin : g_uncapped
            logic unused_in;
            assign unused_in = clk ^ rst ^ clear ^ step;
            assign at_cap    = 1'b0;
        end else begin : g_capped
            localparam int unsigned   CNT_W = $clog2(MAX_POLLS + 2);
            localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_POLLS);

            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst || clear) begin
                    cnt_q <= '0;
                end else if (step && (cnt_q < LIMIT)) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign at_cap = (cnt_q == LIMIT);
        end
    endgenerate

endmodule

// File: rtl/tbp_ctrl.sv
module tbp_ctrl
    import tbp_pkg::*;
#(
    parameter int unsigned AW        = 20,
    parameter int unsigned MAX_POLLS = 1024,
    parameter int unsigned TOG_POS   = TBP_TOGGLE_POS,
    parameter int unsigned TMO_POS   = TBP_TIMEOUT_POS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] poll_addr,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [7:0]    rd_data,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    input  logic          wr_ack,
    output logic          done,
    output logic          pass,
    output logic          fail
);
    tbp_state_e    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic          start_acc;
    logic          rd_go, rd_got;
    logic [7:0]    rd_sample;
    logic          wr_go, wr_sent;
    logic          load_first, load_second, pair_step;
    logic          at_cap;
    logic          finish_pass, finish_fail;
    tbp_flags_t    flags;

    assign start_acc   = start && (state_q == ST_IDLE);
    assign rd_go       = is_fetch_state(state_q) && !rd_req && !rd_got;
    assign wr_go       = (state_q == ST_RESET_WR) && !wr_req && !wr_sent;
    assign load_first  = rd_got && is_first_of_pair(state_q);
    assign load_second = rd_got && is_second_of_pair(state_q);
    assign pair_step   = rd_got && (state_q == ST_RD_B);

    tbp_rd_port #(.AW(AW)) rd_port_i (
        .clk      (clk),
        .rst      (rst),
        .go       (rd_go),
        .go_addr  (addr_q),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .rd_ack   (rd_ack),
        .rd_data  (rd_data),
        .got      (rd_got),
        .got_data (rd_sample)
    );

    tbp_wr_port #(.AW(AW)) wr_port_i (
        .clk     (clk),
        .rst     (rst),
        .go      (wr_go),
        .go_addr (addr_q),
        .go_data (TBP_RESET_CMD),
        .wr_req  (wr_req),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_ack  (wr_ack),
        .sent    (wr_sent)
    );

    tbp_pair_judge #(.TOG_POS(TOG_POS), .TMO_POS(TMO_POS)) judge_i (
        .clk         (clk),
        .rst         (rst),
        .load_first  (load_first),
        .load_second (load_second),
        .sample      (rd_sample),
        .flags       (flags)
    );

    tbp_poll_limit #(.MAX_POLLS(MAX_POLLS)) limit_i (
        .clk    (clk),
        .rst    (rst),
        .clear  (start_acc),
        .step   (pair_step),
        .at_cap (at_cap)
    );

    always_comb begin
        state_d     = state_q;
        finish_pass = 1'b0;
        finish_fail = 1'b0;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_RD_A;
            ST_RD_A:  if (rd_got) state_d = ST_RD_B;
            ST_RD_B:  if (rd_got) state_d = ST_EVAL;
            ST_EVAL: begin
                if (!flags.toggled) begin
                    finish_pass = 1'b1;
                    state_d     = ST_IDLE;
                end else if (flags.expired) begin
                    state_d = ST_CF_A;
                end else if (at_cap) begin
                    state_d = ST_RESET_WR;
                end else begin
                    state_d = ST_RD_A;
                end
            end
            ST_CF_A:  if (rd_got) state_d = ST_CF_B;
            ST_CF_B:  if (rd_got) state_d = ST_CEVAL;
            ST_CEVAL: begin
                if (!flags.toggled) begin
                    finish_pass = 1'b1;
                    state_d     = ST_IDLE;
                end else begin
                    state_d = ST_RESET_WR;
                end
            end
            ST_RESET_WR: begin
                if (wr_sent) begin
                    finish_fail = 1'b1;
                    state_d     = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            done    <= 1'b0;
            pass    <= 1'b0;
            fail    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= finish_pass || finish_fail;
            if (start_acc) begin
                addr_q <= poll_addr;
                pass   <= 1'b0;
                fail   <= 1'b0;
            end else begin
                if (finish_pass) pass <= 1'b1;
                if (finish_fail) fail <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tbp_ctrl_chk.sv
module tbp_ctrl_chk #(
    parameter int unsigned AW = 20
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr,
    input logic          rd_ack,
    input logic          wr_req,
    input logic [7:0]    wr_data,
    input logic          wr_ack,
    input logic          done,
    input logic          pass,
    input logic          fail
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> !(done || pass || fail || rd_req || wr_req));

    p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    p_no_overlap_r2: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && wr_req));

    p_reset_cmd_r6: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> (wr_data == 8'hF0));

    p_fail_after_write_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(fail) |-> $past(wr_req && wr_ack, 2));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_verdict_excl_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pass, fail}));

    p_done_verdict_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (pass ^ fail));

    p_pass_held_r7: assert property (@(posedge clk) disable iff (rst)
        (pass && !start) |=> pass);

    p_fail_held_r7: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> fail);

endmodule

bind tbp_ctrl tbp_ctrl_chk #(.AW(AW)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .rd_ack  (rd_ack),
    .wr_req  (wr_req),
    .wr_data (wr_data),
    .wr_ack  (wr_ack),
    .done    (done),
    .pass    (pass),
    .fail    (fail)
);

// File: tb/tbp_ctrl_tb_top.sv
`timescale 1ns/1ps
module tbp_ctrl_tb_top;
    localparam int AW  = 16;
    localparam int CAP = 6;

    logic          clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] poll_addr = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_ack = 1'b0;
    logic [7:0]    rd_data = '0;
    logic          wr_req;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          wr_ack = 1'b0;
    logic          done, pass, fail;

    tbp_ctrl #(.AW(AW), .MAX_POLLS(CAP)) dut_i (
        .clk(clk), .rst(rst), .start(start), .poll_addr(poll_addr),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .done(done), .pass(pass), .fail(fail)
    );

    logic [7:0]    script [64];
    int            rd_cnt = 0, wr_cnt = 0, done_cnt = 0, addr_err = 0;
    int            rd_wait = 0, wr_wait = 0, rd_lat = 1, wr_lat = 1;
    logic [7:0]    last_wr = '0;
    logic [AW-1:0] exp_addr = '0;
    int            n_chk = 0, n_bad = 0;

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Device model: answers reads from the script, acknowledges writes.
    initial begin
        forever begin
            @(negedge clk);
            if (done) done_cnt++;
            if (rd_ack) begin
                rd_ack = 1'b0;
            end else if (rd_req) begin
                if (rd_wait >= rd_lat) begin
                    rd_ack  = 1'b1;
                    rd_data = script[(rd_cnt < 64) ? rd_cnt : 63];
                    if (rd_addr !== exp_addr) addr_err++;
                    rd_cnt++;
                    rd_wait = 0;
                    rd_lat  = $urandom_range(2, 0);
                end else begin
                    rd_wait++;
                end
            end
            if (wr_ack) begin
                wr_ack = 1'b0;
            end else if (wr_req) begin
                if (wr_wait >= wr_lat) begin
                    wr_ack  = 1'b1;
                    last_wr = wr_data;
                    if (wr_addr !== exp_addr) addr_err++;
                    wr_cnt++;
                    wr_wait = 0;
                    wr_lat  = $urandom_range(2, 0);
                end else begin
                    wr_wait++;
                end
            end
        end
    end

    // Bit 6 flips on each read below 'busy', then stays 1; bit 5 is 1 from read 't5' on.
    function automatic void fill_script(input int busy, input int t5);
        for (int k = 0; k < 64; k++) begin
            logic [7:0] v;
            v    = 8'($urandom);
            v[6] = (k < busy) ? k[0] : 1'b1;
            v[5] = (k >= t5);
            script[k] = v;
        end
    endfunction

    function automatic void predict(output bit ok, output int nreads, output int nwr);
        int i  = 0;
        int it = 0;
        ok = 1'b0;
        nwr = 0;
        for (int g = 0; g < 30; g++) begin
            logic [7:0] a, b, c, d;
            a = script[i]; b = script[i+1]; i += 2; it++;
            if (a[6] == b[6]) begin ok = 1'b1; nwr = 0; break; end
            if (b[5]) begin
                c = script[i]; d = script[i+1]; i += 2;
                ok  = (c[6] == d[6]);
                nwr = ok ? 0 : 1;
                break;
            end
            if (it >= CAP) begin ok = 1'b0; nwr = 1; break; end
        end
        nreads = i;
    endfunction

    task automatic run_case(input string req, input int busy, input int t5, input bit restart);
        bit ok;
        int nreads, nwr, w;
        fill_script(busy, t5);
        predict(ok, nreads, nwr);
        exp_addr  = AW'($urandom);
        poll_addr = exp_addr;
        rd_cnt = 0; wr_cnt = 0; done_cnt = 0; addr_err = 0; last_wr = '0;
        start = 1'b1;
        step();
        start = 1'b0;
        check_eq({req, " R7 verdict cleared at start"}, int'(pass | fail), 0);
        if (restart) begin
            repeat (4) step();
            poll_addr = ~exp_addr;
            start = 1'b1;
            step();
            start = 1'b0;
        end
        w = 0;
        while (!done && w < 3000) begin
            step();
            w++;
        end
        check_eq({req, " completion reached"}, int'(done), 1);
        check_eq({req, " pass flag"}, int'(pass), int'(ok));
        check_eq({req, " fail flag"}, int'(fail), int'(!ok));
        check_eq({req, " R2 read count"}, rd_cnt, nreads);
        check_eq({req, " R6 reset write count"}, wr_cnt, nwr);
        if (nwr != 0) check_eq({req, " R6 reset command value"}, int'(last_wr), 8'hF0);
        repeat (3) step();
        check_eq({req, " R7 done low after pulse"}, int'(done), 0);
        check_eq({req, " R7 single done"}, done_cnt, 1);
        check_eq({req, " R7 verdict held"}, int'(pass), int'(ok));
        check_eq({req, " R2 address"}, addr_err, 0);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        if (seed < 0) seed = 0;
        repeat (3) step();
        check_eq("R1 done in reset", int'(done), 0);
        check_eq("R1 verdict in reset", int'(pass | fail), 0);
        check_eq("R1 bus idle in reset", int'(rd_req | wr_req), 0);
        rst = 1'b0;
        step();
        check_eq("R1 idle after reset", int'(done | pass | fail | rd_req | wr_req), 0);

        run_case("R3 stable first pair", 0, 64, 1'b0);
        run_case("R4 repoll until stable", 4, 64, 1'b0);
        run_case("R5 confirm settles", 2, 1, 1'b0);
        run_case("R6 confirm still flips", 64, 3, 1'b0);
        run_case("R9 cap reached", 64, 64, 1'b0);
        run_case("R8 start ignored while busy", 64, 64, 1'b1);
        for (int n = 0; n < 30; n++) begin
            run_case("R4 random stream", $urandom_range(20, 0), $urandom_range(40, 0), 1'b0);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule